// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

The router takes a wide vector of peripheral interrupt request lines and folds them onto the nine general-purpose inputs of a core event controller, general levels 7 through 15. Each source has its own programmable 4-bit field that selects which level it drives. A per-source enable bit can shut a source out of routing entirely. Each level output is the registered OR of every enabled source currently steered to it.

Software reaches the configuration through a plain register port. The port has a write strobe, a word address, write data and combinational read data. The assignment words pack eight source fields per 32-bit word. An enable word and a read-only view of the raw request lines follow the assignment words. Out of reset the router applies a fixed default steering, so interrupts reach the core before any setup code runs. Software can re-steer a source at any time without disturbing the others.

Top module: `irq_router`

## Requirements
- R1: While reset is held and right after it, every level output is 0 and the enable word reads as all ones for the implemented sources. Source n's assignment field reads n mod 9, so with 16 sources word 0 reads 0x76543210 and word 1 reads 0x65432108.
- R2: A field value v from 0 to 8 steers its source to level 7+v, which is output bit v of `irq_lvl_o`.
- R3: A field value from 9 to 15 steers its source to no level, whatever its request and enable.
- R4: A source whose enable bit is 0 (enable word at address NUM_SRC/8, bit n for source n) drives no level.
- R5: Each output bit is the OR of all enabled, requesting sources steered to that level. With no request, every output is 0.
- R6: An output responds to its inputs one clock edge after they are presented, and not in the same cycle.
- R7: A write that re-steers one source changes the outputs on the clock edge after the write edge. Requests from other sources steered elsewhere stay asserted across the change.
- R8: Word k (k below NUM_SRC/8) holds source 8k+j in bits [4j+3:4j] and reads back what was written. The next address holds the enable word. The one after that returns the raw request lines and ignores writes. Any higher address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Peripheral request lines, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_lvl_o | output | NUM_LVL | Core general-level requests, bit v is level 7+v |

## Verification
The bench targets the edges of the field decoding. It uses value 8, the top valid level, and values 9 and 15, which must route nowhere. A decoder that wraps or truncates the field would fire a wrong level. It checks packing by moving a source in the second nibble of the second word, which catches an off-by-slot index. It re-steers one source while another stays active, so a design that briefly clears all outputs on a write, or lags one cycle extra, shows a dropped or late bit. It also writes to the status address and checks that the raw request view and the outputs are unchanged, which would expose a status word that latched the write.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
   // width of one source's level-select field
   localparam int unsigned FLD_W = 4;

   // default steering applied out of reset: source n to level n mod nlvl
   function automatic logic [FLD_W-1:0] dflt_lvl(input int unsigned src,
                                                  input int unsigned nlvl);
      return FLD_W'(src % nlvl);
   endfunction
endpackage

// File: rtl/irq_rtr_cfg.sv
module irq_rtr_cfg
   import irq_rtr_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   input  logic [NUM_SRC-1:0]               src_i,
   output logic [DATA_W-1:0]                rdata_o,
   output logic [NUM_SRC-1:0][FLD_W-1:0]    asg_o,
   output logic [NUM_SRC-1:0]               en_o
);
   localparam int unsigned SLOTS     = DATA_W / FLD_W;
   localparam int unsigned NASG      = NUM_SRC / SLOTS;
   localparam int unsigned EN_ADDR   = NASG;
   localparam int unsigned STAT_ADDR = NASG + 1;

   logic [NUM_SRC-1:0][FLD_W-1:0] asg_q;
   logic [NUM_SRC-1:0]            en_q;
   logic                          en_wr;

   assign en_wr = we_i && (addr_i == ADDR_W'(EN_ADDR));

   // one field register per source, decoded from its word and slot
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
      localparam int unsigned WORD = s / SLOTS;
      localparam int unsigned SLOT = s % SLOTS;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            asg_q[s] <= dflt_lvl(s, NUM_LVL);
         end else if (we_i && (addr_i == ADDR_W'(WORD))) begin
            asg_q[s] <= wdata_i[FLD_W*SLOT +: FLD_W];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '1;
      end else if (en_wr) begin
         en_q <= wdata_i[NUM_SRC-1:0];
      end
   end

   // read mux: assignment words, enable word, raw request view, zero
   always_comb begin
      rdata_o = '0;
      if (addr_i < ADDR_W'(NASG)) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (ADDR_W'(s / SLOTS) == addr_i) begin
               rdata_o[FLD_W*(s % SLOTS) +: FLD_W] = asg_q[s];
            end
         end
      end else if (addr_i == ADDR_W'(EN_ADDR)) begin
         rdata_o[NUM_SRC-1:0] = en_q;
      end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
         rdata_o[NUM_SRC-1:0] = src_i;
      end
   end

   assign asg_o = asg_q;
   assign en_o  = en_q;

   // R8: enable word captures the written value on the following edge
   a_r8_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_wr |=> (en_o == $past(wdata_i[NUM_SRC-1:0])));

   // R8: no write strobe, no configuration change
   a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> ($stable(asg_o) && $stable(en_o)));

   // R8: writes to the status address alter no configuration state
   a_r8_stat_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(STAT_ADDR)) |=> ($stable(asg_o) && $stable(en_o)));
endmodule

// File: rtl/irq_rtr_fanin.sv
module irq_rtr_fanin
   import irq_rtr_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 9,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [NUM_SRC-1:0]            src_i,
   input  logic [NUM_SRC-1:0]            en_i,
   input  logic [NUM_SRC-1:0][FLD_W-1:0] asg_i,
   output logic [NUM_LVL-1:0]            lvl_o
);
   logic [NUM_SRC-1:0]              live;
   logic [NUM_LVL-1:0][NUM_SRC-1:0] sel;
   logic [NUM_LVL-1:0]              hit;

   assign live = src_i & en_i;

   // one match row per level; field values past the last level match none
   for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign sel[k][s] = (asg_i[s] == FLD_W'(k));
      end
      assign hit[k] = |(live & sel[k]);
   end

   if (REG_OUT) begin : g_reg
      logic [NUM_LVL-1:0] lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) lvl_q <= '0;
         else         lvl_q <= hit;
      end
      assign lvl_o = lvl_q;

      // R4: with every source disabled, no level fires on the next edge
      a_r4_all_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_i == '0) |=> (lvl_o == '0));

      // R5: no request means quiet outputs one edge later
      a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (src_i == '0) |=> (lvl_o == '0));

      // R5: never more levels active than live sources feeding them
      a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> ($countones(lvl_o) <= $countones($past(live))));
   end else begin : g_comb
      assign lvl_o = hit;
      // clock and reset unused in the combinational variant
      logic unused_ok;
      assign unused_ok = clk_i ^ rst_ni;
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_rtr_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic                reg_we_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic [NUM_LVL-1:0]  irq_lvl_o
);
   localparam int unsigned SLOTS = DATA_W / FLD_W;
   localparam int unsigned NASG  = NUM_SRC / SLOTS;

   // elaboration-time parameter checks
   if (DATA_W % FLD_W != 0)            begin : g_chk_dw  $error("DATA_W must hold whole fields"); end
   if (NUM_SRC % SLOTS != 0)           begin : g_chk_ns  $error("NUM_SRC must fill whole words"); end
   if (NUM_SRC > DATA_W)               begin : g_chk_en  $error("enable word too narrow"); end
   if (NUM_LVL > (1 << FLD_W))         begin : g_chk_lv  $error("too many levels for field"); end
   if ((1 << ADDR_W) < NASG + 2)       begin : g_chk_aw  $error("address space too small"); end

   logic [NUM_SRC-1:0][FLD_W-1:0] asg;
   logic [NUM_SRC-1:0]            en;

   irq_rtr_cfg #(
      .NUM_SRC (NUM_SRC),
      .NUM_LVL (NUM_LVL),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) cfg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .src_i   (src_i),
      .rdata_o (reg_rdata_o),
      .asg_o   (asg),
      .en_o    (en)
   );

   irq_rtr_fanin #(
      .NUM_SRC (NUM_SRC),
      .NUM_LVL (NUM_LVL),
      .REG_OUT (1'b1)
   ) fanin_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i),
      .en_i    (en),
      .asg_i   (asg),
      .lvl_o   (irq_lvl_o)
   );

   // R6: a request appearing from nothing cannot show in the same cycle
   a_r6_no_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(src_i) == '0) |-> (irq_lvl_o == '0));
endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
   localparam int unsigned NS = 16;
   localparam int unsigned NL = 9;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int unsigned NVEC = 9;

   // {src, enable, expected levels} under default steering
   localparam logic [40:0] VEC [NVEC] = '{
      {16'h0001, 16'hFFFF, 9'h001},
      {16'h0100, 16'hFFFF, 9'h100},
      {16'h0200, 16'hFFFF, 9'h001},
      {16'h8000, 16'hFFFF, 9'h040},
      {16'h0201, 16'h0001, 9'h001},
      {16'h0201, 16'h0000, 9'h000},
      {16'hFFFF, 16'hFFFF, 9'h1FF},
      {16'h00FF, 16'hFF00, 9'h000},
      {16'h0012, 16'hFFFF, 9'h012}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NL-1:0] irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_router #(.NUM_SRC(NS), .NUM_LVL(NL), .DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_lvl_o(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // write lands on the posedge inside; returns at the following negedge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      check("R1 outputs in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 outputs after reset", 32'(irq), 32'h0);
      rd(4'd0, v); check("R1 default word0", v, 32'h76543210);
      rd(4'd1, v); check("R1 default word1", v, 32'h65432108);
      rd(4'd2, v); check("R1 enable all ones", v, 32'h0000FFFF);
      rd(4'd3, v); check("R8 status idle", v, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         wr(4'd2, {16'h0, VEC[i][24:9]});
         src = VEC[i][40:25];
         @(negedge clk); @(negedge clk);
         check($sformatf("R5/R4 vector %0d", i), 32'(irq), 32'(VEC[i][8:0]));
      end
      wr(4'd2, 32'h0000FFFF);
      src = '0;
      @(negedge clk); @(negedge clk);
      check("R5 idle", 32'(irq), 32'h0);

      // R6 latency
      src = 16'h0010;
      #1 check("R6 not same cycle", 32'(irq), 32'h0);
      @(negedge clk);
      check("R6 one edge later", 32'(irq), 32'h010);

      // R8 status view, read-only, high address
      rd(4'd3, v); check("R8 status raw", v, 32'h0010);
      wr(4'd3, 32'hFFFFFFFF);
      rd(4'd3, v); check("R8 status write ignored", v, 32'h0010);
      rd(4'd2, v); check("R8 enable unchanged by status write", v, 32'h0000FFFF);
      @(negedge clk);
      check("R8 outputs unchanged by status write", 32'(irq), 32'h010);
      rd(4'd7, v); check("R8 unmapped reads zero", v, 32'h0);

      // R2 top level
      wr(4'd0, 32'h76543218);
      src = 16'h0001;
      @(negedge clk); @(negedge clk);
      check("R2 field 8 to bit 8", 32'(irq), 32'h100);
      rd(4'd0, v); check("R8 word0 readback", v, 32'h76543218);

      // R3 unrouted values
      wr(4'd0, 32'h76543219);
      @(negedge clk); @(negedge clk);
      check("R3 field 9 routes nowhere", 32'(irq), 32'h0);
      wr(4'd0, 32'h7654321F);
      @(negedge clk); @(negedge clk);
      check("R3 field 15 routes nowhere", 32'(irq), 32'h0);

      // R8 packing: source 10 sits in nibble 2 of word 1
      wr(4'd1, 32'h65432308);
      src = 16'h0400;
      @(negedge clk); @(negedge clk);
      check("R8 source10 field packing", 32'(irq), 32'h008);

      // R7 re-steer under load
      wr(4'd0, 32'h76543210);
      src = 16'h0003;
      @(negedge clk); @(negedge clk);
      check("R7 before re-steer", 32'(irq), 32'h003);
      wr(4'd0, 32'h76543215);
      check("R7 no change at write edge", 32'(irq), 32'h003);
      @(negedge clk);
      check("R7 new level next edge, other kept", 32'(irq), 32'h022);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule